// File: doc/BRIEF.md
# Operand Effective Address Unit

This block turns one decoded operand specifier into the address that the operand fetch will use. It takes a 4-bit mode code, a register number together with that register's current contents, the current program counter, a signed displacement and an operand size code. It returns the effective address. When the mode modifies its base register, it also returns a writeback request that carries the updated pointer. The deferred modes first compute a pointer location. The block reads that location through a request/response memory port, and the word that comes back becomes the effective address.

A command is taken in through a valid/ready handshake. `cmd_ready` is high only when the unit is idle. The register contents, the PC and the displacement are sampled in the cycle the command is accepted. A result is offered on `res_valid` and is held, together with the writeback fields, until `res_ready` is high at a clock edge. The memory read request `mrd_valid` is held with a stable address until `mrd_ready` is seen. The response on `mrsp_valid` has no back-pressure and is accepted in any cycle after the request was taken.

Top module: `opnd_ea_unit`

## Requirements
- R1: Mode 1 (register indirect) gives the effective address equal to the register contents, and no writeback.
- R2: Mode 2 (post-increment) gives the effective address equal to the register contents, with writeback of the contents plus the operand step.
- R3: Mode 3 (pre-decrement) gives both the effective address and the writeback equal to the register contents minus the operand step.
- R4: The operand step is 1, 2, 4 or 8 bytes for size codes 0, 1, 2 and 3, with wraparound modulo 2^32.
- R5: Mode 4 (displacement) gives the register contents plus the displacement, which is sign-extended from 16 bits. There is no writeback.
- R6: Mode 5 (PC-relative) gives the PC plus the sign-extended displacement. There is no writeback.
- R7: Mode 6 (post-increment deferred) reads memory at the register contents. It returns the word read as the effective address and writes back the register contents plus 4, whatever the size code.
- R8: Mode 7 (displacement deferred) reads memory at the register contents plus the displacement. Mode 8 (PC-relative deferred) reads at the PC plus the displacement. In both, the word read is the effective address and there is no writeback.
- R9: A non-deferred result is valid in the cycle after the command is accepted. A deferred result is valid in the cycle after the memory response arrives, and never earlier.
- R10: While a result is pending, `res_valid`, `res_ea`, `res_err` and the writeback fields hold steady until `res_ready`, and `cmd_ready` stays low.
- R11: A memory request holds `mrd_valid` and `mrd_addr` steady until `mrd_ready`. Non-deferred modes issue no request.
- R12: Mode 0 (register direct) and codes 9 to 15 return `res_err` high with no writeback and no memory read.
- R13: `wb_valid` is high only together with `res_valid`, and it names the register of the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command accepted when valid |
| cmd_mode | input | 4 | Addressing mode code |
| cmd_size | input | 2 | Operand size code |
| cmd_reg | input | 4 | Base register number |
| cmd_reg_data | input | 32 | Contents of the base register |
| cmd_pc | input | 32 | Program counter |
| cmd_disp | input | 16 | Signed displacement |
| mrd_valid | output | 1 | Pointer read request |
| mrd_ready | input | 1 | Memory accepts the request |
| mrd_addr | output | 32 | Pointer location |
| mrsp_valid | input | 1 | Pointer word returned |
| mrsp_data | input | 32 | Pointer word |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumed |
| res_ea | output | 32 | Effective address |
| res_err | output | 1 | No address for this mode |
| wb_valid | output | 1 | Base register update requested |
| wb_reg | output | 4 | Register to update |
| wb_data | output | 32 | New register value |

## Verification
The bench goes after the step sizes across all four size codes. A wrong shift would move the pointer by the wrong amount. It also checks the pre- versus post-modification order: a swapped order shows up as an address off by one step. Further targets are the sign extension of negative displacements, which goes wrong as an address about 64 KiB too high, and wraparound below zero. For the deferred modes it stretches both the request wait and the response latency. A unit that finished early, dropped the request, or used the operand size in place of the 4-byte pointer step would give a premature result or a wrong writeback. The result is held back by the consumer to show that the fields do not drift. Register direct and unused codes must raise the error flag without touching memory or the register.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    AM_REG       = 4'd0,
    AM_IND       = 4'd1,
    AM_INC       = 4'd2,
    AM_DEC       = 4'd3,
    AM_DISP      = 4'd4,
    AM_PCREL     = 4'd5,
    AM_INC_DEF   = 4'd6,
    AM_DISP_DEF  = 4'd7,
    AM_PCREL_DEF = 4'd8
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MREQ  = 2'd1,
    ST_MWAIT = 2'd2,
    ST_DONE  = 2'd3
  } ea_state_e;
endpackage

// File: rtl/ea_calc.sv
module ea_calc #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic [3:0]    mode,
  input  logic [1:0]    size,
  input  logic [AW-1:0] reg_data,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] disp,
  output logic [AW-1:0] addr,
  output logic          wb_en,
  output logic [AW-1:0] wb_val,
  output logic          deferred,
  output logic          err
);
  import ea_pkg::*;

  localparam int PTR_BYTES = AW / 8;

  logic [AW-1:0] dext;
  logic [AW-1:0] step;
  logic [AW-1:0] base;
  logic [AW-1:0] based;

  always_comb begin
    dext  = {{(AW-DW){disp[DW-1]}}, disp};
    step  = AW'(1) << size;
    base  = (mode == AM_PCREL || mode == AM_PCREL_DEF) ? pc : reg_data;
    based = base + dext;

    addr     = '0;
    wb_en    = 1'b0;
    wb_val   = '0;
    deferred = 1'b0;
    err      = 1'b0;
    case (mode)
      AM_IND: addr = base;
      AM_INC: begin
        addr   = base;
        wb_en  = 1'b1;
        wb_val = base + step;
      end
      AM_DEC: begin
        addr   = base - step;
        wb_en  = 1'b1;
        wb_val = base - step;
      end
      AM_DISP, AM_PCREL: addr = based;
      AM_INC_DEF: begin
        addr     = base;
        deferred = 1'b1;
        wb_en    = 1'b1;
        wb_val   = base + AW'(PTR_BYTES);
      end
      AM_DISP_DEF, AM_PCREL_DEF: begin
        addr     = based;
        deferred = 1'b1;
      end
      default: err = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl #(
  parameter int AW  = 32,
  parameter int RAW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [RAW-1:0] cmd_reg,
  input  logic [AW-1:0]  c_addr,
  input  logic           c_wb_en,
  input  logic [AW-1:0]  c_wb_val,
  input  logic           c_deferred,
  input  logic           c_err,
  output logic           mrd_valid,
  input  logic           mrd_ready,
  output logic [AW-1:0]  mrd_addr,
  input  logic           mrsp_valid,
  input  logic [AW-1:0]  mrsp_data,
  output logic           res_valid,
  input  logic           res_ready,
  output logic [AW-1:0]  res_ea,
  output logic           res_err,
  output logic           wb_valid,
  output logic [RAW-1:0] wb_reg,
  output logic [AW-1:0]  wb_data
);
  import ea_pkg::*;

  ea_state_e      state;
  logic [AW-1:0]  ea_q;
  logic           wb_en_q;
  logic [AW-1:0]  wb_val_q;
  logic [RAW-1:0] wb_reg_q;
  logic           err_q;
  logic           accept;

  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ea_q     <= '0;
      wb_en_q  <= 1'b0;
      wb_val_q <= '0;
      wb_reg_q <= '0;
      err_q    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          ea_q     <= c_addr;
          wb_en_q  <= c_wb_en;
          wb_val_q <= c_wb_val;
          wb_reg_q <= cmd_reg;
          err_q    <= c_err;
          state    <= c_deferred ? ST_MREQ : ST_DONE;
        end
        ST_MREQ:  if (mrd_ready) state <= ST_MWAIT;
        ST_MWAIT: if (mrsp_valid) begin
          ea_q  <= mrsp_data;
          state <= ST_DONE;
        end
        ST_DONE:  if (res_ready) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign mrd_valid = (state == ST_MREQ);
  assign mrd_addr  = ea_q;
  assign res_valid = (state == ST_DONE);
  assign res_ea    = ea_q;
  assign res_err   = err_q;
  assign wb_valid  = res_valid && wb_en_q;
  assign wb_reg    = wb_reg_q;
  assign wb_data   = wb_val_q;

  // R11
  mrd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_valid && !mrd_ready |=> mrd_valid && $stable(mrd_addr));
  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_ea) && $stable(res_err)
      && $stable(wb_valid) && $stable(wb_data) && $stable(wb_reg));
  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !cmd_ready);
  // R13
  wb_with_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> res_valid);
  // R12
  err_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_err |-> !wb_valid);
  // R9
  def_no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_valid |=> !res_valid);
endmodule

// File: rtl/opnd_ea_unit.sv
module opnd_ea_unit #(
  parameter int AW  = 32,
  parameter int DW  = 16,
  parameter int RAW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [3:0]     cmd_mode,
  input  logic [1:0]     cmd_size,
  input  logic [RAW-1:0] cmd_reg,
  input  logic [AW-1:0]  cmd_reg_data,
  input  logic [AW-1:0]  cmd_pc,
  input  logic [DW-1:0]  cmd_disp,
  output logic           mrd_valid,
  input  logic           mrd_ready,
  output logic [AW-1:0]  mrd_addr,
  input  logic           mrsp_valid,
  input  logic [AW-1:0]  mrsp_data,
  output logic           res_valid,
  input  logic           res_ready,
  output logic [AW-1:0]  res_ea,
  output logic           res_err,
  output logic           wb_valid,
  output logic [RAW-1:0] wb_reg,
  output logic [AW-1:0]  wb_data
);
  logic [AW-1:0] c_addr;
  logic          c_wb_en;
  logic [AW-1:0] c_wb_val;
  logic          c_deferred;
  logic          c_err;

  ea_calc #(.AW(AW), .DW(DW)) u_calc (
    .mode     (cmd_mode),
    .size     (cmd_size),
    .reg_data (cmd_reg_data),
    .pc       (cmd_pc),
    .disp     (cmd_disp),
    .addr     (c_addr),
    .wb_en    (c_wb_en),
    .wb_val   (c_wb_val),
    .deferred (c_deferred),
    .err      (c_err)
  );

  ea_ctrl #(.AW(AW), .RAW(RAW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_reg    (cmd_reg),
    .c_addr     (c_addr),
    .c_wb_en    (c_wb_en),
    .c_wb_val   (c_wb_val),
    .c_deferred (c_deferred),
    .c_err      (c_err),
    .mrd_valid  (mrd_valid),
    .mrd_ready  (mrd_ready),
    .mrd_addr   (mrd_addr),
    .mrsp_valid (mrsp_valid),
    .mrsp_data  (mrsp_data),
    .res_valid  (res_valid),
    .res_ready  (res_ready),
    .res_ea     (res_ea),
    .res_err    (res_err),
    .wb_valid   (wb_valid),
    .wb_reg     (wb_reg),
    .wb_data    (wb_data)
  );
endmodule

// File: tb/opnd_ea_unit_tb.sv
module opnd_ea_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_mode = '0;
  logic [1:0]  cmd_size = '0;
  logic [3:0]  cmd_reg = '0;
  logic [31:0] cmd_reg_data = '0;
  logic [31:0] cmd_pc = '0;
  logic [15:0] cmd_disp = '0;
  logic        mrd_valid;
  logic        mrd_ready = 1'b0;
  logic [31:0] mrd_addr;
  logic        mrsp_valid = 1'b0;
  logic [31:0] mrsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [31:0] res_ea;
  logic        res_err;
  logic        wb_valid;
  logic [3:0]  wb_reg;
  logic [31:0] wb_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd_ea_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mode(cmd_mode), .cmd_size(cmd_size), .cmd_reg(cmd_reg),
    .cmd_reg_data(cmd_reg_data), .cmd_pc(cmd_pc), .cmd_disp(cmd_disp),
    .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
    .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data), .res_valid(res_valid),
    .res_ready(res_ready), .res_ea(res_ea), .res_err(res_err),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model of one command: returns expectations from the requirements.
  task automatic run_op(input logic [3:0] md, input logic [1:0] sz, input logic [3:0] rn,
                        input logic [31:0] rv, input logic [31:0] pc, input logic [15:0] dp,
                        input logic [31:0] mword, input int req_wait, input int rsp_wait,
                        input int hold, input string req);
    logic [31:0] dx, stp, e_ea, e_wb, e_ptr;
    bit e_wben, e_def, e_err;
    dx = {{16{dp[15]}}, dp};
    stp = 32'd1 << sz;
    e_ea = 0; e_wb = 0; e_ptr = 0; e_wben = 0; e_def = 0; e_err = 0;
    case (md)
      4'd1: e_ea = rv;
      4'd2: begin e_ea = rv; e_wben = 1; e_wb = rv + stp; end
      4'd3: begin e_ea = rv - stp; e_wben = 1; e_wb = rv - stp; end
      4'd4: e_ea = rv + dx;
      4'd5: e_ea = pc + dx;
      4'd6: begin e_def = 1; e_ptr = rv; e_wben = 1; e_wb = rv + 32'd4; e_ea = mword; end
      4'd7: begin e_def = 1; e_ptr = rv + dx; e_ea = mword; end
      4'd8: begin e_def = 1; e_ptr = pc + dx; e_ea = mword; end
      default: e_err = 1;
    endcase

    @(negedge clk);
    check({req, " cmd_ready idle"}, 32'(cmd_ready), 32'd1);
    cmd_valid = 1; cmd_mode = md; cmd_size = sz; cmd_reg = rn;
    cmd_reg_data = rv; cmd_pc = pc; cmd_disp = dp;
    @(negedge clk);
    cmd_valid = 0; cmd_reg_data = 32'hDEAD_BEEF; cmd_pc = 32'hDEAD_BEEF;
    if (e_def) begin
      for (int i = 0; i < req_wait; i++) begin
        check({req, " R11 req held"}, 32'(mrd_valid), 32'd1);
        check({req, " R11 req addr"}, mrd_addr, e_ptr);
        check({req, " R9 no early result"}, 32'(res_valid), 32'd0);
        @(negedge clk);
      end
      check({req, " R11 req valid"}, 32'(mrd_valid), 32'd1);
      check({req, " R11 req addr"}, mrd_addr, e_ptr);
      mrd_ready = 1;
      @(negedge clk);
      mrd_ready = 0;
      check({req, " R11 req dropped"}, 32'(mrd_valid), 32'd0);
      for (int i = 0; i < rsp_wait; i++) begin
        check({req, " R9 waits for response"}, 32'(res_valid), 32'd0);
        @(negedge clk);
      end
      mrsp_valid = 1; mrsp_data = mword;
      @(negedge clk);
      mrsp_valid = 0; mrsp_data = 32'h0BAD_0BAD;
    end else begin
      check({req, " R11 R12 no mem read"}, 32'(mrd_valid), 32'd0);
    end
    for (int i = 0; i <= hold; i++) begin
      check({req, " R9 R10 res_valid"}, 32'(res_valid), 32'd1);
      check({req, " R10 cmd_ready low"}, 32'(cmd_ready), 32'd0);
      check({req, " R12 res_err"}, 32'(res_err), 32'(e_err));
      if (!e_err) check({req, " ea"}, res_ea, e_ea);
      check({req, " R13 wb_valid"}, 32'(wb_valid), 32'(e_wben));
      if (e_wben) begin
        check({req, " wb_data"}, wb_data, e_wb);
        check({req, " R13 wb_reg"}, 32'(wb_reg), 32'(rn));
      end
      res_ready = (i == hold);
      @(negedge clk);
    end
    res_ready = 0;
    check({req, " R10 result retired"}, 32'(res_valid), 32'd0);
    check({req, " R10 ready again"}, 32'(cmd_ready), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("reset res_valid", 32'(res_valid), 32'd0);
    check("reset mrd_valid", 32'(mrd_valid), 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("reset cmd_ready", 32'(cmd_ready), 32'd1);

    run_op(4'd1, 2'd2, 4'd3, 32'h0000_1000, 32'h0, 16'h0, 0, 0, 0, 0, "R1 indirect");
    run_op(4'd2, 2'd0, 4'd5, 32'h0000_2000, 32'h0, 16'h0, 0, 0, 0, 1, "R2 R4 inc byte");
    run_op(4'd2, 2'd1, 4'd5, 32'h0000_2000, 32'h0, 16'h0, 0, 0, 0, 0, "R2 R4 inc word");
    run_op(4'd2, 2'd2, 4'd6, 32'h0000_2000, 32'h0, 16'h0, 0, 0, 0, 0, "R2 R4 inc long");
    run_op(4'd2, 2'd3, 4'd7, 32'hFFFF_FFFC, 32'h0, 16'h0, 0, 0, 0, 0, "R2 R4 inc quad wrap");
    run_op(4'd3, 2'd3, 4'd8, 32'h0000_0100, 32'h0, 16'h0, 0, 0, 0, 2, "R3 R4 dec quad");
    run_op(4'd3, 2'd1, 4'd9, 32'h0000_0000, 32'h0, 16'h0, 0, 0, 0, 0, "R3 R4 dec wrap");
    run_op(4'd4, 2'd0, 4'd1, 32'h0000_2000, 32'h0, 16'h0040, 0, 0, 0, 0, "R5 disp pos");
    run_op(4'd4, 2'd0, 4'd1, 32'h0000_2000, 32'h0, 16'hFFF0, 0, 0, 0, 0, "R5 disp neg");
    run_op(4'd5, 2'd2, 4'd0, 32'h1234_5678, 32'h0001_0000, 16'h8000, 0, 0, 0, 0, "R6 pcrel neg");
    run_op(4'd5, 2'd2, 4'd0, 32'h1234_5678, 32'h0000_4000, 16'h7FFF, 0, 0, 0, 1, "R6 pcrel pos");
    run_op(4'd6, 2'd0, 4'd2, 32'h0000_3000, 32'h0, 16'h0, 32'hCAFE_0010, 2, 3, 2, "R7 inc deferred");
    run_op(4'd6, 2'd3, 4'd4, 32'h0000_3004, 32'h0, 16'h0, 32'h0000_ABCD, 0, 0, 0, "R7 inc deferred quad");
    run_op(4'd7, 2'd1, 4'd3, 32'h0000_5000, 32'h0, 16'hFFFC, 32'h7777_0000, 1, 0, 0, "R8 disp deferred");
    run_op(4'd8, 2'd1, 4'd3, 32'h0000_5000, 32'h0008_0000, 16'h0020, 32'h0000_9ABC, 0, 4, 1, "R8 pcrel deferred");
    run_op(4'd0, 2'd2, 4'd3, 32'h0000_1000, 32'h0, 16'h0, 0, 0, 0, 0, "R12 reg direct");
    run_op(4'd9, 2'd2, 4'd3, 32'h0000_1000, 32'h0, 16'h0, 0, 0, 0, 1, "R12 code 9");
    run_op(4'd15, 2'd2, 4'd3, 32'h0000_1000, 32'h0, 16'h0, 0, 0, 0, 0, "R12 code 15");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule